// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit I/O virtual address into a physical address by reading descriptors from a two-level translation table kept in memory. A client hands it a virtual address together with the current table base. The walker then reads one or two 32-bit words over a single-outstanding read port. It decodes each word by its two low bits and reports the physical address, or a fault together with the virtual address that caused it.

Three mapping sizes are resolved. A first-level word can map a whole 1 MiB section directly. It can instead link to a 256-entry second-level table, whose words map 64 KiB large pages or 4 KiB small pages. A large page is entered as the same word repeated in 16 neighbouring second-level slots, so any slot inside the run yields the same frame. The walker accepts one request, finishes it with a one-cycle done pulse, and only then accepts the next.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req` and `done` are 0.
- R2: The first read of a walk goes to address {base[31:14], va[31:20], 2'b00}. Bits 13:0 of the base are ignored.
- R3: A first-level word with low bits 2'b10 ends the walk with physical address {word[31:20], va[19:0]} and `done_fault` 0. Exactly one read is issued for that walk.
- R4: A first-level word with low bits 2'b00 or 2'b11 ends the walk with `done_fault` 1, `done_paddr` 0 and `done_vaddr` equal to the request address. No second read is issued.
- R5: A first-level word with low bits 2'b01 causes a second read at address {word[31:10], va[19:12], 2'b00}.
- R6: A second-level word with low bits 2'b01 gives physical address {word[31:16], va[15:0]}. Each of the 16 slots that hold the same large-page word gives the same frame.
- R7: A second-level word with bit 1 set (low bits 2'b10 or 2'b11) gives physical address {word[31:12], va[11:0]}.
- R8: A second-level word with low bits 2'b00 ends the walk with `done_fault` 1, `done_paddr` 0 and `done_vaddr` equal to the request address.
- R9: `done` is high for exactly one cycle per walk. `req_ready` is 0 from the cycle after acceptance until the cycle after `done`. A `req_valid` that arrives while busy is ignored.
- R10: `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_rvalid` high. A `mem_rvalid` that arrives while no read is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request taken when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | First-level table base (16 KiB aligned) |
| mem_req | output | 1 | Descriptor read outstanding |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a translation fault |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_vaddr | output | 32 | Virtual address of the finished walk |

## Verification
Suppose the control state is wrong, for example a link taken for a section or a stale latched address. The very next read then goes out on `mem_addr` with the wrong value, or a read appears that should not exist. The per-clock comparison of the read port catches this within one cycle of the descriptor arriving. A wrong decode of the returned word shows in `done_paddr` or `done_fault` on the done cycle. Lost or doubled completions show as `req_ready` or `done` that disagree with the reference in the cycle after the pulse.

// File: rtl/walk_pkg.sv
// Shared constants and types for the two-level page table walker.
// Assumes 32-bit addresses, 1 MiB sections, 4 KiB small pages and
// 64 KiB large pages.
package walk_pkg;
    localparam int AW          = 32;
    localparam int SECT_LSB    = 20;   // virtual address bits above this index the first level
    localparam int LARGE_LSB   = 16;   // large page offset width
    localparam int SMALL_LSB   = 12;   // small page offset width
    localparam int L2_BASE_LSB = 10;   // second-level table alignment
    localparam int L1_BASE_LSB = 14;   // first-level table alignment
    localparam int WORD_LSB    = 2;    // descriptor size is four bytes

    typedef enum logic [1:0] {
        L1_FAULT   = 2'd0,
        L1_SECTION = 2'd1,
        L1_LINK    = 2'd2
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'd0,
        L2_LARGE = 2'd1,
        L2_SMALL = 2'd2
    } l2_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_RESP = 2'd3
    } walk_state_e;
endpackage

// File: rtl/walk_l1_decode.sv
// First-level descriptor decoder (combinational).
// Classifies the word by its two low bits and forms both the section
// physical address and the second-level descriptor address.
// Assumes the word is only meaningful while a first-level read completes.
module walk_l1_decode
    import walk_pkg::*;
(
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] vaddr,
    output l1_kind_e      kind,
    output logic [AW-1:0] sect_pa,
    output logic [AW-1:0] next_addr
);
    localparam int IDX_W = SECT_LSB - SMALL_LSB;

    logic unused_bits;
    assign unused_bits = ^{desc[L2_BASE_LSB-1:WORD_LSB], vaddr[AW-1:SECT_LSB], vaddr[SMALL_LSB-1:0]};

    // Classify the first-level word.
    always_comb begin
        unique case (desc[1:0])
            2'b10:   kind = L1_SECTION;
            2'b01:   kind = L1_LINK;
            default: kind = L1_FAULT;
        endcase
    end

    // Section frame with the low virtual bits as offset.
    assign sect_pa   = {desc[AW-1:SECT_LSB], vaddr[SECT_LSB-1:0]};
    // Second-level slot address inside the linked table.
    assign next_addr = {desc[AW-1:L2_BASE_LSB], vaddr[SECT_LSB-1 -: IDX_W], {WORD_LSB{1'b0}}};
endmodule

// File: rtl/walk_l2_decode.sv
// Second-level descriptor decoder (combinational).
// Bit 1 set marks a small page, 2'b01 a large page, 2'b00 a fault.
// A large page word is repeated in 16 slots, so the frame uses only
// word bits above the 64 KiB boundary.
module walk_l2_decode
    import walk_pkg::*;
(
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] vaddr,
    output l2_kind_e      kind,
    output logic [AW-1:0] pa
);
    logic unused_bits;
    assign unused_bits = ^{desc[SMALL_LSB-1:WORD_LSB], vaddr[AW-1:LARGE_LSB]};

    // Classify and form the frame address for each page size.
    always_comb begin
        if (desc[1]) begin
            kind = L2_SMALL;
            pa   = {desc[AW-1:SMALL_LSB], vaddr[SMALL_LSB-1:0]};
        end else if (desc[0]) begin
            kind = L2_LARGE;
            pa   = {desc[AW-1:LARGE_LSB], vaddr[LARGE_LSB-1:0]};
        end else begin
            kind = L2_FAULT;
            pa   = '0;
        end
    end
endmodule

// File: rtl/walk_ctrl.sv
// Walk sequencer: accepts one request, issues the first-level read,
// follows a link to the second level if needed, then pulses done.
// Assumes at most one read outstanding and that read data arrives
// only while mem_req is high (other data is ignored).
module walk_ctrl
    import walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic [AW-1:0] req_base,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  l1_kind_e      l1_kind,
    input  logic [AW-1:0] l1_pa,
    input  logic [AW-1:0] l1_next,
    input  l2_kind_e      l2_kind,
    input  logic [AW-1:0] l2_pa,
    output logic [AW-1:0] va_q,
    output logic          done,
    output logic          done_fault,
    output logic [AW-1:0] done_paddr
);
    walk_state_e   state;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] pa_q;
    logic          fault_q;
    logic          unused_base;

    assign unused_base = ^req_base[L1_BASE_LSB-1:0];

    // Sequence the walk and hold its results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            va_q    <= '0;
            addr_q  <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    addr_q <= {req_base[AW-1:L1_BASE_LSB], req_vaddr[AW-1:SECT_LSB], {WORD_LSB{1'b0}}};
                    state  <= ST_L1;
                end
                ST_L1: if (mem_rvalid) begin
                    unique case (l1_kind)
                        L1_SECTION: begin
                            pa_q    <= l1_pa;
                            fault_q <= 1'b0;
                            state   <= ST_RESP;
                        end
                        L1_LINK: begin
                            addr_q <= l1_next;
                            state  <= ST_L2;
                        end
                        default: begin
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                            state   <= ST_RESP;
                        end
                    endcase
                end
                ST_L2: if (mem_rvalid) begin
                    pa_q    <= l2_pa;
                    fault_q <= (l2_kind == L2_FAULT);
                    state   <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign mem_req    = (state == ST_L1) || (state == ST_L2);
    assign mem_addr   = addr_q;
    assign done       = (state == ST_RESP);
    assign done_fault = fault_q;
    assign done_paddr = pa_q;

    // R9: completion lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: walker is free again right after completion.
    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    // R10: an unanswered read keeps its request and address.
    a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R3 / R4: a first-level word that is not a link finishes without a second read.
    a_r3_no_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L1 && mem_rvalid && l1_kind != L1_LINK) |=> (done && !mem_req));
    // R4 / R8: a fault never reports a frame.
    a_r8_fault_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_paddr == '0));
    // R10: a read is never outstanding while a new request could be taken.
    a_r10_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
endmodule

// File: rtl/iova_walker.sv
// Top of the two-level page table walker. Wires the sequencer to the
// two descriptor decoders; the decoders see the read data port directly
// and the sequencer picks the result for the level being read.
module iova_walker
    import walk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_vaddr,
    input  logic [31:0]   req_base,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          done,
    output logic          done_fault,
    output logic [31:0]   done_paddr,
    output logic [31:0]   done_vaddr
);
    l1_kind_e      l1_kind;
    l2_kind_e      l2_kind;
    logic [AW-1:0] l1_pa;
    logic [AW-1:0] l1_next;
    logic [AW-1:0] l2_pa;
    logic [AW-1:0] va_q;

    walk_l1_decode u_l1 (
        .desc      (mem_rdata),
        .vaddr     (va_q),
        .kind      (l1_kind),
        .sect_pa   (l1_pa),
        .next_addr (l1_next)
    );

    walk_l2_decode u_l2 (
        .desc  (mem_rdata),
        .vaddr (va_q),
        .kind  (l2_kind),
        .pa    (l2_pa)
    );

    walk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_base   (req_base),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .l1_kind    (l1_kind),
        .l1_pa      (l1_pa),
        .l1_next    (l1_next),
        .l2_kind    (l2_kind),
        .l2_pa      (l2_pa),
        .va_q       (va_q),
        .done       (done),
        .done_fault (done_fault),
        .done_paddr (done_paddr)
    );

    assign done_vaddr = va_q;
endmodule

// File: tb/iova_walker_test.sv
`timescale 1ns/1ps
module iova_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        done_fault;
    logic [31:0] done_paddr;
    logic [31:0] done_vaddr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] mem [logic [31:0]];

    always #2 clk = ~clk;

    iova_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_base(req_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .done_fault(done_fault),
        .done_paddr(done_paddr), .done_vaddr(done_vaddr)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: list of expected read addresses and result.
    task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                            output logic [31:0] a0, output logic [31:0] a1, output int nreads,
                            output bit flt, output logic [31:0] pa);
        logic [31:0] d1, d2;
        a0 = (base & 32'hFFFF_C000) + ((va >> 20) * 4);
        a1 = 32'h0;
        d1 = rd(a0);
        nreads = 1; flt = 1; pa = 32'h0;
        if (d1[1:0] == 2'b10) begin
            flt = 0; pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
        end else if (d1[1:0] == 2'b01) begin
            nreads = 2;
            a1 = (d1 & 32'hFFFF_FC00) + (((va >> 12) % 256) * 4);
            d2 = rd(a1);
            if (d2[1]) begin
                flt = 0; pa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
            end else if (d2[0]) begin
                flt = 0; pa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF);
            end
        end
    endtask

    // Drive one walk and compare the ports on every clock against the reference.
    task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input int lat,
                            input bit poke, input string req);
        logic [31:0] a0, a1, pa, ea;
        int nreads, seen, cyc;
        bit flt, got;
        ref_walk(va, base, a0, a1, nreads, flt, pa);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_base = base;
        @(negedge clk);
        req_valid = 0;
        check(req_ready == 1'b0, "R9 busy after accept", {31'b0, req_ready}, 32'h0);
        if (poke) begin req_valid = 1; req_vaddr = ~va; req_base = 32'h00FF_0000; end
        seen = 0; cyc = 0; got = 0;
        while (!got && cyc < 40) begin
            cyc++;
            if (done) begin
                got = 1;
                check(seen == nreads, {req, " read count"}, seen, nreads);
                check(done_fault == flt, {req, " fault flag"}, {31'b0, done_fault}, {31'b0, flt});
                check(done_paddr == pa, {req, " paddr"}, done_paddr, pa);
                check(done_vaddr == va, {req, " vaddr"}, done_vaddr, va);
            end else if (mem_req) begin
                ea = (seen == 0) ? a0 : a1;
                check(seen < nreads, {req, " unexpected read R4"}, mem_addr, 32'h0);
                check(mem_addr == ea, (seen == 0) ? "R2 L1 address" : "R5 L2 address", mem_addr, ea);
                seen++;
                for (int k = 1; k < lat; k++) begin
                    @(negedge clk);
                    check(mem_req && mem_addr == ea, "R10 hold", mem_addr, ea);
                end
                mem_rvalid = 1; mem_rdata = rd(mem_addr);
                @(negedge clk);
                mem_rvalid = 0; mem_rdata = 32'hDEAD_BEEF;
            end else begin
                check(req_ready == 1'b0, "R9 busy", {31'b0, req_ready}, 32'h0);
                @(negedge clk);
            end
        end
        check(got, {req, " completion"}, {31'b0, got}, 32'h1);
        req_valid = 0;
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", {31'b0, done}, 32'h0);
        check(req_ready == 1'b1, "R9 ready after done", {31'b0, req_ready}, 32'h1);
    endtask

    localparam logic [31:0] BASE_A = 32'h0004_0000;
    localparam logic [31:0] BASE_B = 32'h000C_1234;

    initial begin
        mem[BASE_A + 32'h123 * 4] = 32'hABC0_0002;   // section
        mem[BASE_A + 32'h005 * 4] = 32'h0000_0000;   // fault 00
        mem[BASE_A + 32'h006 * 4] = 32'h1111_1113;   // fault 11
        mem[BASE_A + 32'h007 * 4] = 32'h0008_0401;   // link
        mem[32'h0008_0400 + 32'h03 * 4] = 32'h5555_6002;  // small 10
        mem[32'h0008_0400 + 32'h04 * 4] = 32'h9999_A003;  // small 11
        for (int i = 16; i < 32; i++) mem[32'h0008_0400 + i * 4] = 32'h7777_0001;  // large run
        mem[32'h000C_0000] = 32'hFFF0_0002;          // section under second base

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
        check(mem_req == 1'b0, "R1 no read", {31'b0, mem_req}, 32'h0);
        check(done == 1'b0, "R1 no done", {31'b0, done}, 32'h0);

        run_walk(32'h1230_0456, BASE_A, 1, 0, "R3 section");
        run_walk(32'h0050_0000, BASE_A, 2, 0, "R4 fault 00");
        run_walk(32'h0060_0ABC, BASE_A, 1, 0, "R4 fault 11");
        run_walk(32'h0070_3ABC, BASE_A, 3, 0, "R7 small");
        run_walk(32'h0070_4001, BASE_A, 1, 0, "R7 small 11");
        run_walk(32'h0071_5123, BASE_A, 2, 0, "R6 large");
        run_walk(32'h0071_F000, BASE_A, 1, 0, "R6 large last slot");
        run_walk(32'h0071_0FFF, BASE_A, 1, 1, "R9 busy request ignored");
        run_walk(32'h0070_5000, BASE_A, 2, 0, "R8 l2 fault");
        run_walk(32'h000A_BCDE, BASE_B, 1, 0, "R2 base low bits");

        // R10: stray read data while idle has no effect
        @(negedge clk);
        mem_rvalid = 1; mem_rdata = 32'h0000_0002;
        @(negedge clk);
        mem_rvalid = 0;
        check(mem_req == 1'b0 && done == 1'b0, "R10 stray rvalid", {30'b0, mem_req, done}, 32'h0);
        check(req_ready == 1'b1, "R10 still idle", {31'b0, req_ready}, 32'h1);
        run_walk(32'h1230_0001, BASE_A, 1, 0, "R10 walk after stray data");

        // R1: reset mid-walk returns to idle
        @(negedge clk);
        req_valid = 1; req_vaddr = 32'h0070_3000; req_base = BASE_A;
        @(negedge clk);
        req_valid = 0; rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_req == 1'b0, "R1 reset mid-walk", {30'b0, req_ready, mem_req}, 32'h2);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule